// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

A purely combinational arithmetic-logic unit for an accumulator-style processor datapath. It receives two 8-bit operands, a carry-in bit and a 3-bit operation code. It returns an 8-bit result, an 8-bit condition-flag vector and a write-enable for the accumulator.

Four operations are arithmetic: add, add with carry, subtract and subtract with borrow. Three are bitwise: AND, XOR and OR. The last is compare. Compare produces the flags of a subtraction and holds the write-enable low, so the accumulator keeps its value.

Every flag follows a fixed rule for each operation. This includes the two flag bits that mirror result bits 3 and 5, and a half-carry that takes the carry-in into account. Register storage, the flag register itself, decimal adjust, shifts and 16-bit arithmetic are handled elsewhere in the datapath.

Top module: `alu8_unit`

## Requirements
- R1: Operation code 0 (add) and 1 (add with carry) form the 9-bit sum a + b + cin, where cin is carry_i for code 1 and 0 for code 0. res_o is the low 8 bits of the sum, and the carry flag is bit 8.
- R2: Operation code 2 (subtract) and 3 (subtract with borrow) form the 9-bit difference a − b − cin, where cin is carry_i for code 3 and 0 for code 2. res_o is the low 8 bits, and the carry flag is bit 8 of the difference, which acts as the borrow.
- R3: Operation code 7 (compare) produces the result and flags of a subtract that has no carry-in. wr_en_o is 0 for code 7 and 1 for every other code.
- R4: The subtract flag is 1 for codes 2, 3 and 7, and 0 for all other codes.
- R5: For add operations the parity/overflow flag is bit 7 of ~(a^b) & (a^z). For subtract and compare it is bit 7 of (a^b) & (a^z). Here z is the 8-bit result.
- R6: For add, subtract and compare the half-carry flag is bit 4 of a^b^z. It is forced to 1 for AND (code 4) and forced to 0 for XOR (code 5) and OR (code 6).
- R7: The sign flag copies result bit 7. The zero flag is 1 exactly when the result is 0x00. The flag at vector bit 5 copies result bit 5. The flag at vector bit 3 copies result bit 3.
- R8: For AND, XOR and OR the result is the bitwise operation, the carry flag is 0, and the parity/overflow flag is 1 when the result has an even number of one bits.
- R9: flags_o is ordered from bit 7 down to bit 0 as: sign, zero, copy of result bit 5, half-carry, copy of result bit 3, parity/overflow, subtract, carry.
- R10: carry_i has no effect on res_o, flags_o or wr_en_o for codes 0, 2, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry-in, used only by add with carry and subtract with borrow |
| op_i | input | 3 | Operation code: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare |
| res_o | output | 8 | Operation result |
| flags_o | output | 8 | Condition flags in the order given in R9 |
| wr_en_o | output | 1 | Accumulator write-enable, low for compare |

## Verification
The block has no registers, so every output is due in the same cycle as its inputs: zero cycles of latency. The bench drives operands, code and carry-in together. It waits a short settling delay, well inside one clock period, and then compares res_o, flags_o and wr_en_o against a reference model. That model derives half-carry from nibble sums and overflow from signed range checks. Because no result is held in a register, no check depends on an earlier stimulus. A hand-computed table of boundary cases comes first, and after it a sweep of every operand pair under every code and both carry-in values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W   = 8;
  localparam int HALF_BIT = 4;
  localparam int Y_BIT    = 5;
  localparam int X_BIT    = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CP  = 3'd7
  } alu_op_e;

  // bit order is consumed by the flag register: s z y h x pv n c
  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          use_cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] z_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic          half_o
);
  localparam int MSB = DW - 1;

  logic          c_eff;
  logic [DW:0]   wide;
  logic [DW-1:0] diff_xz;

  assign c_eff = cin_i & use_cin_i;

  always_comb begin
    if (sub_i) wide = {1'b0, x_i} - {1'b0, y_i} - (DW+1)'(c_eff);
    else       wide = {1'b0, x_i} + {1'b0, y_i} + (DW+1)'(c_eff);
  end

  assign z_o     = wide[DW-1:0];
  assign carry_o = wide[DW];
  assign diff_xz = x_i ^ z_o;

  // subtract overflows when operand signs differ, add when they match
  always_comb begin
    if (sub_i) ovf_o = (x_i[MSB] ^ y_i[MSB]) & diff_xz[MSB];
    else       ovf_o = ~(x_i[MSB] ^ y_i[MSB]) & diff_xz[MSB];
  end

  assign half_o = x_i[HALF_BIT] ^ y_i[HALF_BIT] ^ z_o[HALF_BIT];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [1:0]    sel_i,   // 00 and, 01 xor, 10 or
  output logic [DW-1:0] z_o,
  output logic          half_o,
  output logic          par_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        2'b01:   z_o[i] = x_i[i] ^ y_i[i];
        2'b10:   z_o[i] = x_i[i] | y_i[i];
        default: z_o[i] = x_i[i] & y_i[i];
      endcase
    end
  end

  assign half_o = (sel_i == 2'b00);
  assign par_o  = ~(^z_o);
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
(
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       carry_i,
  input  logic [2:0] op_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);
  localparam int DW = DATA_W;

  alu_op_e    op;
  logic       is_logic;
  logic       is_sub;
  logic       use_cin;

  logic [DW-1:0] ar_z;
  logic          ar_c, ar_v, ar_h;
  logic [DW-1:0] lg_z;
  logic          lg_h, lg_p;

  logic [DW-1:0] z;
  alu_flags_t    fl;

  assign op       = alu_op_e'(op_i);
  assign is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
  assign use_cin  = (op == OP_ADC) || (op == OP_SBC);

  alu8_arith #(.DW(DW)) u_arith (
    .x_i      (a_i),
    .y_i      (b_i),
    .cin_i    (carry_i),
    .use_cin_i(use_cin),
    .sub_i    (is_sub),
    .z_o      (ar_z),
    .carry_o  (ar_c),
    .ovf_o    (ar_v),
    .half_o   (ar_h)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .x_i   (a_i),
    .y_i   (b_i),
    .sel_i (op_i[1:0]),
    .z_o   (lg_z),
    .half_o(lg_h),
    .par_o (lg_p)
  );

  always_comb begin
    z     = is_logic ? lg_z : ar_z;
    fl.s  = z[DW-1];
    fl.z  = (z == '0);
    fl.y  = z[Y_BIT];
    fl.h  = is_logic ? lg_h : ar_h;
    fl.x  = z[X_BIT];
    fl.pv = is_logic ? lg_p : ar_v;
    fl.n  = is_sub;
    fl.c  = is_logic ? 1'b0 : ar_c;
  end

  assign res_o   = z;
  assign flags_o = fl;
  assign wr_en_o = (op != OP_CP);

  always_comb begin
    AST_CP_NO_WRITE: assert (!(op_i == 3'd7 && wr_en_o)); // R3
    AST_N_FOLLOWS_SUB: assert (flags_o[1] == (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7)); // R4
    AST_LOGIC_NO_CARRY: assert (!(is_logic && flags_o[0])); // R8
    AST_ZERO_FLAG: assert (flags_o[6] == (res_o == 8'h00)); // R7
    AST_XY_COPY: assert (flags_o[5] == res_o[5] && flags_o[3] == res_o[3]); // R7
    AST_AND_HALF: assert (!(op_i == 3'd4 && !flags_o[4])); // R6
  end
endmodule

// File: tb/sim_alu8_unit.sv
module sim_alu8_unit;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       cin;
  logic [2:0] op;
  logic [7:0] res, flg;
  logic       we;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  alu8_unit u0 (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .res_o(res), .flags_o(flg), .wr_en_o(we)
  );

  // {op, a, b, cin, res, flags, we}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 8'h0F, 8'h01, 1'b1, 8'h10, 8'h10, 1'b1},  // R1 R6 R10
    {3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h94, 1'b1},  // R5
    {3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h51, 1'b1},  // R1
    {3'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h51, 1'b1},  // R1 R6
    {3'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h1A, 1'b1},  // R2
    {3'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 8'h3E, 1'b1},  // R5
    {3'd3, 8'h00, 8'h00, 1'b1, 8'hFF, 8'hBB, 1'b1},  // R2
    {3'd7, 8'h42, 8'h42, 1'b1, 8'h00, 8'h42, 1'b0},  // R3
    {3'd4, 8'hF0, 8'h3C, 1'b1, 8'h30, 8'h34, 1'b1},  // R8
    {3'd5, 8'hFF, 8'h01, 1'b0, 8'hFE, 8'hA8, 1'b1},  // R8
    {3'd6, 8'h00, 8'h00, 1'b0, 8'h00, 8'h44, 1'b1},  // R8
    {3'd2, 8'h00, 8'h01, 1'b1, 8'hFF, 8'hBB, 1'b1},  // R10
    {3'd7, 8'h01, 8'h02, 1'b0, 8'hFF, 8'hBB, 1'b0},  // R3
    {3'd6, 8'h28, 8'h00, 1'b1, 8'h28, 8'h2C, 1'b1}   // R7 R9
  };

  function automatic logic [16:0] ref_model(input int o, input int x, input int y, input int c);
    int ce, full, sx, sy, sr, r, ones;
    logic s, zf, yf, h, xf, pv, n, cf, w;
    ce = (o == 1 || o == 3) ? c : 0;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    h = 0; pv = 0; cf = 0;
    n = (o == 2 || o == 3 || o == 7);
    if (o <= 1) begin
      full = x + y + ce; r = full % 256; cf = (full > 255);
      h = ((x % 16) + (y % 16) + ce) > 15;
      sr = sx + sy + ce; pv = (sr > 127 || sr < -128);
    end else if (o <= 3 || o == 7) begin
      full = x - y - ce; r = (full + 256) % 256; cf = (full < 0);
      h = (x % 16) < ((y % 16) + ce);
      sr = sx - sy - ce; pv = (sr > 127 || sr < -128);
    end else begin
      r = (o == 4) ? (x & y) : (o == 5) ? (x ^ y) : (x | y);
      h = (o == 4);
      ones = 0;
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      pv = (ones % 2 == 0);
    end
    s = r[7]; zf = (r == 0); yf = r[5]; xf = r[3];
    w = (o != 7);
    return {w, s, zf, yf, h, xf, pv, n, cf, 8'(r)};
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d actual we/flags/res=%b/%h/%h expected=%b/%h/%h",
               tag, op, a, b, cin, act[16], act[15:8], act[7:0], exp_v[16], exp_v[15:8], exp_v[7:0]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    a = '0; b = '0; cin = 1'b0; op = '0;
    @(negedge clk);
    // directed table, hand-computed R1..R10
    for (int i = 0; i < NV; i++) begin
      {op, a, b, cin} = VEC[i][36:17];
      #2;
      check("R1-table/R9", {we, flg, res}, {VEC[i][0], VEC[i][8:1], VEC[i][16:9]});
    end
    // R10: toggling carry_i must not change outputs for codes that ignore it
    for (int o = 0; o < 8; o++) begin
      logic [16:0] o0;
      if (o == 1 || o == 3) continue;
      op = 3'(o); a = 8'h8F; b = 8'h71; cin = 1'b0; #2;
      o0 = {we, flg, res};
      cin = 1'b1; #2;
      check("R10", {we, flg, res}, o0);
    end
    // exhaustive sweep, one aggregated check per code and carry-in (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int o = 0; o < 8; o++) begin
      for (int c = 0; c < 2; c++) begin
        int bad = 0;
        logic [16:0] first_act = '0, first_exp = '0;
        logic [7:0]  fa = '0, fb = '0;
        for (int x = 0; x < 256; x++) begin
          for (int y = 0; y < 256; y++) begin
            logic [16:0] e;
            op = 3'(o); a = 8'(x); b = 8'(y); cin = 1'(c);
            #1;
            e = ref_model(o, x, y, c);
            if ({we, flg, res} !== e) begin
              if (bad == 0) begin first_act = {we, flg, res}; first_exp = e; fa = a; fb = b; end
              bad++;
            end
          end
        end
        checks++;
        if (bad != 0) begin
          errors++;
          $display("FAIL R1/R2/R3/R5/R6/R7/R8 sweep op=%0d cin=%0d a=%h b=%h actual=%h expected=%h (%0d mismatches)",
                   o, c, fa, fb, first_act, first_exp, bad);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule